// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block is a watchdog for a single clock domain. Software sets it up and services it over a small register bus: an 8-bit byte offset, a write strobe with 32-bit data, a read strobe and 32-bit combinational read data. Once armed, a down-counter runs. It is loaded from one of sixteen power-of-two periods, and a 4-bit code picks the period. Software must write a fixed key to the restart register before the count runs out.

The block has two response styles. In the direct style, expiry starts a system-reset pulse straight away. In the two-stage style, the first expiry raises an interrupt line and loads a fresh period. If a second expiry arrives while that interrupt is still pending, the reset pulse follows. The reset pulse has a fixed width. After it the block stays inert, with the counter held at zero, until the block itself is reset. The enable cannot be cleared by software.

Two timeout codes are kept. The arming code sets the first load after enable. The running code sets every later load. A change to either code only matters at the next load.

Top module: `wdog_top`

## Requirements
- R1: After block reset the control word (offset 0x00) reads 0, the range word (offset 0x04) reads 0, the count (offset 0x08) reads 0, and both `irq_o` and `sys_rst_o` are low.
- R2: Control bit 0 is the enable. Once it is 1, a software write of 0 to it leaves it at 1. Control bit 1 picks the response: 0 resets on expiry, 1 interrupts first.
- R3: A write that sets the enable loads the counter with 2^(BASE_EXP+A)-1, where A is the arming code in range bits [7:4]. The counter then falls by one per clock. Code i thus gives a period of 2^(BASE_EXP+i) clocks.
- R4: Writing exactly 0x76 to offset 0x0C while enabled loads the counter from the running code and clears a pending interrupt. Any other value written there, or any write while disabled, changes nothing.
- R5: A write of the running code (range bits [3:0]) does not alter the count in progress. The new code is used at the next load.
- R6: In direct mode (control bit 1 = 0), the clock after the counter reaches zero drives `sys_rst_o` high for exactly RST_W cycles.
- R7: In two-stage mode with no interrupt pending, expiry sets `irq_o` and loads the counter from the running code.
- R8: In two-stage mode, expiry with the interrupt still pending starts the reset pulse. Expiry after the interrupt was cleared raises the interrupt again instead.
- R9: Offset 0x10 reads the interrupt state in bit 0. A read of offset 0x14 returns the same bit and clears the interrupt without reloading the counter.
- R10: Once the reset pulse has fired, the counter reads 0 and restart writes have no effect until block reset.
- R11: Offset 0xF4 reads 0x40 (bit 6: fixed power-of-two periods), 0xF8 reads 0x00010300 and 0xFC reads 0x57440100. Offset 0x0C and unmapped offsets read 0. Writes to read-only offsets change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for bus and counter |
| rst_n | input | 1 | Active-low asynchronous block reset |
| bus_addr | input | 8 | Byte offset of the register accessed |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe (acts only for the clear-on-read offset) |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| irq_o | output | 1 | Pending first-stage interrupt |
| sys_rst_o | output | 1 | System reset pulse, RST_W cycles wide |

## Verification
The bench uses a small BASE_EXP so that real expiries happen within a short run. It counts clocks exactly from the arming write to each load, so a period that is off by one, or a first load that takes the running code instead of the arming code, shows up as a wrong count read. It writes a near-miss key, a clear of the enable, a new running code mid-count and writes to the count register, then reads the count back. A design that obeyed any of these writes would show a jump in the count. It checks the interrupt-clearing read and the second expiry, so that a design which reloads on the clear, or which resets on the first expiry, is caught. It measures the reset pulse at both ends and then sends a restart, which a design that revives after the pulse would act on.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    // register offsets; software decodes these, so they are fixed
    localparam logic [7:0] OFS_CTRL  = 8'h00;
    localparam logic [7:0] OFS_RANGE = 8'h04;
    localparam logic [7:0] OFS_COUNT = 8'h08;
    localparam logic [7:0] OFS_KICK  = 8'h0C;
    localparam logic [7:0] OFS_STAT  = 8'h10;
    localparam logic [7:0] OFS_ACK   = 8'h14;
    localparam logic [7:0] OFS_PARAM = 8'hF4;
    localparam logic [7:0] OFS_VER   = 8'hF8;
    localparam logic [7:0] OFS_KIND  = 8'hFC;

    localparam logic [31:0] KICK_KEY   = 32'h0000_0076;
    localparam logic [31:0] PARAM_WORD = 32'h0000_0040;
    localparam logic [31:0] VER_WORD   = 32'h0001_0300;
    localparam logic [31:0] KIND_WORD  = 32'h5744_0100;

    typedef enum logic {
        RESP_RESET = 1'b0,
        RESP_IRQ   = 1'b1
    } resp_e;

endpackage

// File: rtl/wdog_regfile.sv
module wdog_regfile
    import wdog_pkg::*;
#(
    parameter int CODE_W = 4,
    parameter int CNT_W  = 31
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [7:0]        addr_i,
    input  logic              wr_i,
    input  logic              rd_i,
    input  logic [31:0]       wdata_i,
    input  logic [CNT_W-1:0]  cnt_i,
    input  logic              irq_i,
    output logic              en_o,
    output resp_e             mode_o,
    output logic [CODE_W-1:0] init_code_o,
    output logic [CODE_W-1:0] run_code_o,
    output logic              start_o,
    output logic              kick_o,
    output logic              ack_o,
    output logic [31:0]       rdata_o
);

    typedef struct packed {
        logic              en;
        resp_e             mode;
        logic [CODE_W-1:0] init_code;
        logic [CODE_W-1:0] run_code;
    } reg_t;

    reg_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        start_o = 1'b0;
        kick_o  = 1'b0;
        ack_o   = 1'b0;
        if (wr_i) begin
            case (addr_i)
                OFS_CTRL: begin
                    st_d.mode = resp_e'(wdata_i[1]);
                    if (wdata_i[0] && !st_q.en) begin
                        st_d.en = 1'b1;
                        start_o = 1'b1;
                    end
                end
                OFS_RANGE: begin
                    st_d.run_code  = wdata_i[CODE_W-1:0];
                    st_d.init_code = wdata_i[2*CODE_W-1:CODE_W];
                end
                OFS_KICK: begin
                    if (wdata_i == KICK_KEY && st_q.en) begin
                        kick_o = 1'b1;
                    end
                end
                default: ;
            endcase
        end
        if (rd_i && addr_i == OFS_ACK) begin
            ack_o = 1'b1;
        end
    end

    always_comb begin
        case (addr_i)
            OFS_CTRL:  rdata_o = {30'd0, logic'(st_q.mode), st_q.en};
            OFS_RANGE: rdata_o = 32'({st_q.init_code, st_q.run_code});
            OFS_COUNT: rdata_o = 32'(cnt_i);
            OFS_STAT:  rdata_o = {31'd0, irq_i};
            OFS_ACK:   rdata_o = {31'd0, irq_i};
            OFS_PARAM: rdata_o = PARAM_WORD;
            OFS_VER:   rdata_o = VER_WORD;
            OFS_KIND:  rdata_o = KIND_WORD;
            default:   rdata_o = 32'd0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{en: 1'b0, mode: RESP_RESET, init_code: '0, run_code: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign en_o        = st_q.en;
    assign mode_o      = st_q.mode;
    assign init_code_o = st_q.init_code;
    assign run_code_o  = st_q.run_code;

    AST_ENABLE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.en |=> st_q.en); // R2

endmodule

// File: rtl/wdog_counter.sv
module wdog_counter
    import wdog_pkg::*;
#(
    parameter int BASE_EXP = 16,
    parameter int CODE_W   = 4,
    parameter int CNT_W    = 31
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  resp_e             mode_i,
    input  logic [CODE_W-1:0] init_code_i,
    input  logic [CODE_W-1:0] run_code_i,
    input  logic              start_i,
    input  logic              kick_i,
    input  logic              ack_i,
    output logic [CNT_W-1:0]  cnt_o,
    output logic              irq_o,
    output logic              fire_o,
    output logic              dead_o
);

    localparam int NCODES = 1 << CODE_W;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             irq;
        logic             dead;
    } cnt_t;

    cnt_t st_d, st_q;

    logic [CNT_W-1:0] reload_tbl [NCODES];

    for (genvar g = 0; g < NCODES; g++) begin : g_tbl
        assign reload_tbl[g] = CNT_W'((64'd1 << (BASE_EXP + g)) - 64'd1);
    end

    always_comb begin
        st_d   = st_q;
        fire_o = 1'b0;
        if (ack_i) begin
            st_d.irq = 1'b0;
        end
        if (st_q.dead) begin
            st_d.cnt = '0;
        end else if (start_i) begin
            st_d.cnt = reload_tbl[init_code_i];
        end else if (en_i) begin
            if (kick_i) begin
                st_d.cnt = reload_tbl[run_code_i];
                st_d.irq = 1'b0;
            end else if (st_q.cnt != '0) begin
                st_d.cnt = st_q.cnt - CNT_W'(1);
            end else if (mode_i == RESP_IRQ && !st_q.irq) begin
                st_d.irq = 1'b1;
                st_d.cnt = reload_tbl[run_code_i];
            end else begin
                fire_o    = 1'b1;
                st_d.dead = 1'b1;
                st_d.cnt  = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_o  = st_q.cnt;
    assign irq_o  = st_q.irq;
    assign dead_o = st_q.dead;

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && !st_q.dead && !kick_i && st_q.cnt != '0)
        |=> st_q.cnt == $past(st_q.cnt) - CNT_W'(1)); // R3
    AST_KICK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (kick_i && !st_q.dead) |=> !st_q.irq); // R4
    AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.irq) |-> $past(mode_i == RESP_IRQ)); // R7
    AST_SECOND_STAGE: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(st_q.dead) && $past(mode_i == RESP_IRQ)) |-> $past(st_q.irq)); // R8
    AST_DEAD_STUCK: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.dead |=> (st_q.dead && st_q.cnt == '0)); // R10

endmodule

// File: rtl/wdog_pulse.sv
module wdog_pulse #(
    parameter int WIDTH = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fire_i,
    output logic pulse_o
);

    localparam int PW = $clog2(WIDTH + 1);

    typedef struct packed {
        logic          active;
        logic [PW-1:0] left;
    } pls_t;

    pls_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (fire_i) begin
            st_d.active = 1'b1;
            st_d.left   = PW'(WIDTH - 1);
        end else if (st_q.active) begin
            if (st_q.left == '0) begin
                st_d.active = 1'b0;
            end else begin
                st_d.left = st_q.left - PW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pulse_o = st_q.active;

    AST_FIRE_STARTS_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        fire_i |=> pulse_o); // R6

endmodule

// File: rtl/wdog_top.sv
module wdog_top
    import wdog_pkg::*;
#(
    parameter int BASE_EXP = 16,
    parameter int CODE_W   = 4,
    parameter int RST_W    = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [7:0]  bus_addr,
    input  logic        bus_wr,
    input  logic [31:0] bus_wdata,
    input  logic        bus_rd,
    output logic [31:0] bus_rdata,
    output logic        irq_o,
    output logic        sys_rst_o
);

    localparam int CNT_W = BASE_EXP + (1 << CODE_W) - 1;

    logic              en;
    resp_e             mode;
    logic [CODE_W-1:0] init_code;
    logic [CODE_W-1:0] run_code;
    logic              start;
    logic              kick;
    logic              ack;
    logic [CNT_W-1:0]  cnt;
    logic              irq;
    logic              fire;
    logic              dead;

    wdog_regfile #(.CODE_W(CODE_W), .CNT_W(CNT_W)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .addr_i      (bus_addr),
        .wr_i        (bus_wr),
        .rd_i        (bus_rd),
        .wdata_i     (bus_wdata),
        .cnt_i       (cnt),
        .irq_i       (irq),
        .en_o        (en),
        .mode_o      (mode),
        .init_code_o (init_code),
        .run_code_o  (run_code),
        .start_o     (start),
        .kick_o      (kick),
        .ack_o       (ack),
        .rdata_o     (bus_rdata)
    );

    wdog_counter #(.BASE_EXP(BASE_EXP), .CODE_W(CODE_W), .CNT_W(CNT_W)) u_cnt (
        .clk         (clk),
        .rst_n       (rst_n),
        .en_i        (en),
        .mode_i      (mode),
        .init_code_i (init_code),
        .run_code_i  (run_code),
        .start_i     (start),
        .kick_i      (kick),
        .ack_i       (ack),
        .cnt_o       (cnt),
        .irq_o       (irq),
        .fire_o      (fire),
        .dead_o      (dead)
    );

    wdog_pulse #(.WIDTH(RST_W)) u_pulse (
        .clk     (clk),
        .rst_n   (rst_n),
        .fire_i  (fire),
        .pulse_o (sys_rst_o)
    );

    assign irq_o = irq;

    AST_RST_NEEDS_EXPIRY: assert property (@(posedge clk) disable iff (!rst_n)
        sys_rst_o |-> (dead && en)); // R10

endmodule

// File: tb/sim_wdog_top.sv
`timescale 1ns/1ps
module sim_wdog_top;
    import wdog_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = 32'd0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_rdata;
    logic        irq_o;
    logic        sys_rst_o;

    always #10 clk = ~clk;

    wdog_top #(.BASE_EXP(2), .CODE_W(4), .RST_W(8)) u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rd    (bus_rd),
        .bus_rdata (bus_rdata),
        .irq_o     (irq_o),
        .sys_rst_o (sys_rst_o)
    );

    typedef struct {
        int          kind;   // 0 read data, 1 irq pin, 2 reset pin
        logic [31:0] exp;
        string       tag;
    } exp_t;

    exp_t sbq[$];
    logic chk_req = 1'b0;
    int   n_checks = 0;
    int   n_errors = 0;
    bit   finished = 1'b0;

    // monitor: compares at the falling edge, away from the active edge
    always @(negedge clk) begin
        if (chk_req && sbq.size() > 0) begin
            exp_t it;
            logic [31:0] act;
            it = sbq.pop_front();
            case (it.kind)
                0:       act = bus_rdata;
                1:       act = {31'd0, irq_o};
                default: act = {31'd0, sys_rst_o};
            endcase
            n_checks++;
            if (act !== it.exp) begin
                n_errors++;
                $display("FAIL %s: actual=%h expected=%h", it.tag, act, it.exp);
            end
        end
    end

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        tick();
        bus_wr = 1'b0;
    endtask

    task automatic chk(input int kind, input logic [7:0] a, input logic [31:0] e, input string tag);
        exp_t it;
        it.kind = kind;
        it.exp  = e;
        it.tag  = tag;
        sbq.push_back(it);
        bus_addr = a;
        bus_rd   = (kind == 0);
        chk_req  = 1'b1;
        tick();
        bus_rd  = 1'b0;
        chk_req = 1'b0;
    endtask

    task automatic rdchk(input logic [7:0] a, input logic [31:0] e, input string tag);
        chk(0, a, e, tag);
    endtask

    task automatic irqchk(input logic e, input string tag);
        chk(1, 8'h20, {31'd0, e}, tag);
    endtask

    task automatic rstchk(input logic e, input string tag);
        chk(2, 8'h20, {31'd0, e}, tag);
    endtask

    task automatic block_reset();
        rst_n = 1'b0;
        idle(3);
        rst_n = 1'b1;
        tick();
    endtask

    initial begin
        #(20 * 150000);
        if (!finished) begin
            n_errors++;
            $display("FAIL watchdog: actual=hung expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        block_reset();

        // R1 reset state
        rdchk(OFS_CTRL,  32'd0, "R1 ctrl");
        rdchk(OFS_RANGE, 32'd0, "R1 range");
        rdchk(OFS_COUNT, 32'd0, "R1 count");
        irqchk(1'b0, "R1 irq");
        rstchk(1'b0, "R1 reset out");

        // R4 restart while disabled does nothing
        wr(OFS_KICK, 32'h76);
        rdchk(OFS_COUNT, 32'd0, "R4 kick while disabled");

        // R11 constants and unmapped
        rdchk(OFS_PARAM, 32'h0000_0040, "R11 param");
        rdchk(OFS_VER,   32'h0001_0300, "R11 version");
        rdchk(OFS_KIND,  32'h5744_0100, "R11 type");
        rdchk(8'h20,     32'd0,         "R11 unmapped");
        rdchk(OFS_KICK,  32'd0,         "R11 restart reads zero");

        // direct mode: arming code 2 (16 clocks), running code 1 (8 clocks)
        wr(OFS_RANGE, 32'h21);
        wr(OFS_CTRL, 32'h1);                    // count 15
        rdchk(OFS_COUNT, 32'd15, "R3 first load"); // -> 14
        wr(OFS_KICK, 32'h77);                   // -> 13
        rdchk(OFS_COUNT, 32'd13, "R4 wrong key ignored"); // -> 12
        wr(OFS_CTRL, 32'h0);                    // -> 11
        rdchk(OFS_CTRL, 32'd1, "R2 enable sticky"); // -> 10
        wr(OFS_COUNT, 32'hFFFF);                // -> 9
        rdchk(OFS_COUNT, 32'd9, "R11 count write ignored"); // -> 8
        wr(OFS_RANGE, 32'h23);                  // -> 7
        rdchk(OFS_COUNT, 32'd7, "R5 code change mid-count"); // -> 6
        wr(OFS_KICK, 32'h76);                   // reload with code 3: 31
        rdchk(OFS_COUNT, 32'd31, "R5 new code at reload"); // -> 30
        idle(29);                               // -> 1
        rdchk(OFS_COUNT, 32'd1, "R3 countdown"); // -> 0
        rstchk(1'b0, "R6 before expiry");       // expiry at this edge
        rstchk(1'b1, "R6 pulse start");
        rdchk(OFS_COUNT, 32'd0, "R10 count held");
        idle(5);
        rstchk(1'b1, "R6 pulse last cycle");
        rstchk(1'b0, "R6 pulse end");
        wr(OFS_KICK, 32'h76);
        rdchk(OFS_COUNT, 32'd0, "R10 restart after pulse ignored");
        rstchk(1'b0, "R10 no second pulse");

        // two-stage mode
        block_reset();
        wr(OFS_RANGE, 32'h21);
        wr(OFS_CTRL, 32'h3);                    // count 15
        rdchk(OFS_CTRL, 32'd3, "R2 mode bit"); // -> 14
        idle(14);                               // -> 0
        irqchk(1'b0, "R7 before expiry");       // first expiry at this edge
        irqchk(1'b1, "R7 interrupt raised");    // count 7 -> 6
        rdchk(OFS_STAT, 32'd1, "R9 status");    // -> 5
        rdchk(OFS_COUNT, 32'd5, "R7 reload from running code"); // -> 4
        wr(OFS_KICK, 32'h76);                   // count 7, irq clear
        irqchk(1'b0, "R4 restart clears interrupt"); // -> 6
        idle(7);                                // reaches 0, expiry: irq, 7
        irqchk(1'b1, "R7 raised again");        // -> 6
        rdchk(OFS_ACK, 32'd1, "R9 clear-read data"); // clear, -> 5
        irqchk(1'b0, "R9 interrupt cleared");   // -> 4
        rdchk(OFS_COUNT, 32'd4, "R9 no reload on clear"); // -> 3
        idle(4);                                // expiry with irq clear: irq, 7
        rstchk(1'b0, "R8 cleared irq gives no reset"); // -> 6
        irqchk(1'b1, "R8 interrupt instead");   // -> 5
        idle(5);                                // -> 0
        rstchk(1'b0, "R8 before second expiry");
        rstchk(1'b1, "R8 second expiry resets");

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule